// File: doc/BRIEF.md
# Indirect Control Memory Access Controller

This block lets a host register port reach an internal control memory indirectly. Each memory word holds two fields: a 4-bit code and an 8-bit data value. The host first loads a data register and an address register. It then writes a command byte that starts a single read, a single write or a whole-memory fill. While the operation runs, a busy output stays high. A read returns the addressed word in a readback register.

All memory operations execute in a separate reference-clock domain. Host requests cross into that domain through a toggle handshake over two-flop synchronizers, and completion crosses back the same way. A two-bit mode register sets how long a single access takes. A fast initialization mode skips the extra wait cycles that normal operation inserts. An enable output tells the serial switching interfaces whether they may run, and it is high only in normal operation.

Top module: `ctlmem_access`

## Requirements
- R1: After reset, busy is 0, the mode register is 00, switch_en is 0, and both readback fields are 0.
- R2: A write to register select 2 (command) while idle raises busy at the next clock edge. Busy stays high until the reference-clock side reports completion, and only a command write can raise it.
- R3: While busy is high, writes to select 0 (data), select 1 (address) and select 2 (command) are ignored. They change no register and start no new operation.
- R4: Select 3 writes the mode register from wr_data[1:0], and it takes effect at the next edge. Encodings: 00 bulk reset, 10 fast initialization, 11 normal. switch_en equals (mode == 11), delayed by one clock.
- R5: A command with bit 7 = 0 and bit 6 = 0 writes the word at the address register. Bit 0 set writes the data field from the data register. Bit 1 set writes the code field from data register bits [3:0]. A cleared bit leaves that field unchanged.
- R6: A command with bit 7 = 1 and bit 6 = 0 loads the addressed code and data fields into rd_code and rd_data in the same cycle that busy falls. The readback outputs never change while busy stays low.
- R7: A command with bit 6 = 1 fills every word: code 0000 and data equal to the data register.
- R8: A fill keeps busy high for at least 256 reference-clock cycles and for no more than 256 plus 20 reference-clock cycles.
- R9: In fast initialization mode, a single access keeps busy high for at most 40 host cycles at a 3:1 clock ratio. In normal mode, a single access takes at least 12 host cycles longer, because of the inserted wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Host synchronous active-high reset |
| ref_clk | input | 1 | Reference clock for memory operations |
| ref_rst | input | 1 | Reference-domain synchronous active-high reset |
| wr_en | input | 1 | Host register write strobe |
| wr_sel | input | 2 | Register select: 0 data, 1 address, 2 command, 3 mode |
| wr_data | input | 8 | Host write value |
| busy | output | 1 | Memory operation in progress |
| mode | output | 2 | Current operation mode |
| switch_en | output | 1 | Serial switching interfaces allowed to run |
| rd_code | output | 4 | Readback code field |
| rd_data | output | 8 | Readback data field |

## Verification
The hardest situation to reach is a register write that lands while an operation is still crossing between clock domains. The bench issues a write command and then, inside the handshake window, rewrites the data, address and command registers. It then uses later commands to show that the first operation used the original values, that the data register kept its old contents, and that no second operation started. The full-memory fill is checked with a 256-address read sweep. That sweep runs after a prior sweep has written a distinct code and data pattern into every word, so any word the fill skipped would show up.

// File: rtl/ctlmem_pkg.sv
package ctlmem_pkg;
  typedef enum logic [1:0] {
    MODE_CLR  = 2'b00,
    MODE_RSVD = 2'b01,
    MODE_INIT = 2'b10,
    MODE_RUN  = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_ACC, ST_CAPT, ST_FILL, ST_DONE
  } eng_st_e;

  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;
  localparam logic [1:0] SEL_MODE = 2'd3;

  localparam int CMD_RD_BIT    = 7;
  localparam int CMD_FILL_BIT  = 6;
  localparam int CMD_WCODE_BIT = 1;
  localparam int CMD_WDATA_BIT = 0;
endpackage

// File: rtl/ctlmem_sync.sv
module ctlmem_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ctlmem_ram.sv
module ctlmem_ram #(
  parameter int AW = 8,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdat,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdat
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdat;
    rdat <= mem[raddr];
  end
endmodule

// File: rtl/ctlmem_host.sv
module ctlmem_host
  import ctlmem_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CODE_W = 4,
  parameter int HOST_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [HOST_W-1:0] wr_data,
  input  logic              ack_s,
  input  logic [CODE_W-1:0] res_code,
  input  logic [DATA_W-1:0] res_data,
  output logic              busy,
  output logic [1:0]        mode_q,
  output logic              switch_en,
  output logic [CODE_W-1:0] rd_code,
  output logic [DATA_W-1:0] rd_data,
  output logic              req_tgl,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic [HOST_W-1:0] cmd_q,
  output logic [1:0]        op_mode
);
  logic ack_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      mode_q    <= MODE_CLR;
      switch_en <= 1'b0;
      rd_code   <= '0;
      rd_data   <= '0;
      req_tgl   <= 1'b0;
      ack_seen  <= 1'b0;
      addr_q    <= '0;
      data_q    <= '0;
      cmd_q     <= '0;
      op_mode   <= MODE_CLR;
    end else begin
      switch_en <= (mode_q == MODE_RUN);
      if (wr_en && wr_sel == SEL_MODE) mode_q <= wr_data[1:0];
      if (!busy) begin
        if (wr_en) begin
          case (wr_sel)
            SEL_DATA: data_q <= wr_data[DATA_W-1:0];
            SEL_ADDR: addr_q <= wr_data[ADDR_W-1:0];
            SEL_CMD: begin
              cmd_q   <= wr_data;
              op_mode <= mode_q;
              busy    <= 1'b1;
              req_tgl <= ~req_tgl;
            end
            default: ;
          endcase
        end
      end else if (ack_s != ack_seen) begin
        ack_seen <= ack_s;
        busy     <= 1'b0;
        if (cmd_q[CMD_RD_BIT] && !cmd_q[CMD_FILL_BIT]) begin
          rd_code <= res_code;
          rd_data <= res_data;
        end
      end
    end
  end
endmodule

// File: rtl/ctlmem_engine.sv
module ctlmem_engine
  import ctlmem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CODE_W    = 4,
  parameter int HOST_W    = 8,
  parameter int WAIT_NORM = 6,
  parameter int WAIT_INIT = 0
) (
  input  logic              ref_clk,
  input  logic              ref_rst,
  input  logic              req_s,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  input  logic [HOST_W-1:0] cmd,
  input  logic [1:0]        op_mode,
  input  logic [CODE_W-1:0] ram_code,
  input  logic [DATA_W-1:0] ram_data,
  output logic              we_code,
  output logic              we_data,
  output logic [ADDR_W-1:0] waddr,
  output logic [CODE_W-1:0] wcode,
  output logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] raddr,
  output logic              ack_tgl,
  output logic [CODE_W-1:0] res_code,
  output logic [DATA_W-1:0] res_data
);
  localparam int CNT_W = $clog2(WAIT_NORM + WAIT_INIT + 2);

  eng_st_e            st;
  logic               req_prev;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  idx;

  always_comb begin
    raddr   = addr;
    we_code = 1'b0;
    we_data = 1'b0;
    waddr   = addr;
    wcode   = data[CODE_W-1:0];
    wdata   = data;
    if (st == ST_ACC && !cmd[CMD_RD_BIT]) begin
      we_code = cmd[CMD_WCODE_BIT];
      we_data = cmd[CMD_WDATA_BIT];
    end else if (st == ST_FILL) begin
      we_code = 1'b1;
      we_data = 1'b1;
      waddr   = idx;
      wcode   = '0;
    end
  end

  always_ff @(posedge ref_clk) begin
    if (ref_rst) begin
      st       <= ST_IDLE;
      req_prev <= 1'b0;
      ack_tgl  <= 1'b0;
      cnt      <= '0;
      idx      <= '0;
      res_code <= '0;
      res_data <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_s != req_prev) begin
          req_prev <= req_s;
          if (cmd[CMD_FILL_BIT]) begin
            idx <= '0;
            st  <= ST_FILL;
          end else begin
            cnt <= (op_mode == MODE_INIT) ? CNT_W'(WAIT_INIT) : CNT_W'(WAIT_NORM);
            st  <= ST_WAIT;
          end
        end
        ST_WAIT: if (cnt == '0) st <= ST_ACC; else cnt <= cnt - 1'b1;
        ST_ACC:  st <= ST_CAPT;
        ST_CAPT: begin
          if (cmd[CMD_RD_BIT]) begin
            res_code <= ram_code;
            res_data <= ram_data;
          end
          st <= ST_DONE;
        end
        ST_FILL: begin
          idx <= idx + 1'b1;
          if (idx == '1) st <= ST_DONE;
        end
        ST_DONE: begin
          ack_tgl <= ~ack_tgl;
          st      <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ctlmem_access.sv
module ctlmem_access
  import ctlmem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int CODE_W    = 4,
  parameter int HOST_W    = 8,
  parameter int WAIT_NORM = 6,
  parameter int WAIT_INIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_clk,
  input  logic              ref_rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [HOST_W-1:0] wr_data,
  output logic              busy,
  output logic [1:0]        mode,
  output logic              switch_en,
  output logic [CODE_W-1:0] rd_code,
  output logic [DATA_W-1:0] rd_data
);
  logic              req_tgl, req_s, ack_tgl, ack_s;
  logic [ADDR_W-1:0] addr_q, waddr, raddr;
  logic [DATA_W-1:0] data_q, wdata, ram_data, res_data;
  logic [CODE_W-1:0] wcode, ram_code, res_code;
  logic [HOST_W-1:0] cmd_q;
  logic [1:0]        op_mode;
  logic              we_code, we_data;

  ctlmem_host #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .HOST_W(HOST_W)) u_host (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ack_s(ack_s), .res_code(res_code), .res_data(res_data),
    .busy(busy), .mode_q(mode), .switch_en(switch_en),
    .rd_code(rd_code), .rd_data(rd_data), .req_tgl(req_tgl),
    .addr_q(addr_q), .data_q(data_q), .cmd_q(cmd_q), .op_mode(op_mode)
  );

  ctlmem_sync #(.W(1)) u_req_sync (.clk(ref_clk), .rst(ref_rst), .d(req_tgl), .q(req_s));
  ctlmem_sync #(.W(1)) u_ack_sync (.clk(clk), .rst(rst), .d(ack_tgl), .q(ack_s));

  ctlmem_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CODE_W(CODE_W), .HOST_W(HOST_W),
                  .WAIT_NORM(WAIT_NORM), .WAIT_INIT(WAIT_INIT)) u_eng (
    .ref_clk(ref_clk), .ref_rst(ref_rst), .req_s(req_s),
    .addr(addr_q), .data(data_q), .cmd(cmd_q), .op_mode(op_mode),
    .ram_code(ram_code), .ram_data(ram_data),
    .we_code(we_code), .we_data(we_data), .waddr(waddr), .wcode(wcode), .wdata(wdata),
    .raddr(raddr), .ack_tgl(ack_tgl), .res_code(res_code), .res_data(res_data)
  );

  ctlmem_ram #(.AW(ADDR_W), .W(CODE_W)) u_code_ram (
    .clk(ref_clk), .we(we_code), .waddr(waddr), .wdat(wcode), .raddr(raddr), .rdat(ram_code)
  );

  ctlmem_ram #(.AW(ADDR_W), .W(DATA_W)) u_data_ram (
    .clk(ref_clk), .we(we_data), .waddr(waddr), .wdat(wdata), .raddr(raddr), .rdat(ram_data)
  );
endmodule

// File: rtl/ctlmem_access_chk.sv
module ctlmem_access_chk #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 4,
  parameter int HOST_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_sel,
  input logic [HOST_W-1:0] wr_data,
  input logic              busy,
  input logic [1:0]        mode,
  input logic              switch_en,
  input logic [CODE_W-1:0] rd_code,
  input logic [DATA_W-1:0] rd_data
);
  p_busy_from_cmd_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wr_en && wr_sel == 2'd2));

  p_mode_write_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_sel == 2'd3) |=> (mode == $past(wr_data[1:0])));

  p_switch_mode_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (switch_en == ($past(mode) == 2'b11)));

  p_rd_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy)) |-> ($stable(rd_data) && $stable(rd_code)));
endmodule

bind ctlmem_access ctlmem_access_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W), .HOST_W(HOST_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .busy(busy), .mode(mode), .switch_en(switch_en), .rd_code(rd_code), .rd_data(rd_data)
);

// File: tb/ctlmem_access_test.sv
module ctlmem_access_test;
  logic       clk = 1'b0, ref_clk = 1'b0, rst = 1'b1, ref_rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       busy, switch_en;
  logic [1:0] mode;
  logic [3:0] rd_code;
  logic [7:0] rd_data;
  int checks = 0, failures = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;
  always #30 ref_clk = ~ref_clk;

  ctlmem_access uut (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .ref_rst(ref_rst),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .busy(busy), .mode(mode), .switch_en(switch_en), .rd_code(rd_code), .rd_data(rd_data)
  );

  function automatic logic [7:0] dpat(int a);
    return 8'((a * 37 + 11) & 8'hff);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] sel, logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (busy && cyc < 3000) begin
      cyc++;
      @(negedge clk);
    end
    if (cyc >= 3000) chk(1'b0, "R2 busy timeout", cyc, 0);
  endtask

  task automatic run_cmd(logic [7:0] c, output int cyc);
    wr_reg(2'd2, c);
    wait_idle(cyc);
  endtask

  task automatic read_at(int a);
    int cyc;
    wr_reg(2'd1, 8'(a));
    run_cmd(8'h80, cyc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int cyc, norm_cyc, init_cyc, fill_cyc, e1;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge ref_clk); ref_rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(mode == 2'b00, "R1 mode", mode, 0);
    chk(switch_en == 1'b0, "R1 switch_en", switch_en, 0);
    chk(rd_code == 0 && rd_data == 0, "R1 readback", {rd_code, rd_data}, 0);

    // R4 every mode encoding
    for (int m = 0; m < 4; m++) begin
      wr_reg(2'd3, 8'(m));
      chk(mode == 2'(m), "R4 mode reg", mode, m);
      @(negedge clk);
      chk(switch_en == (m == 3), "R4 switch_en", switch_en, (m == 3));
    end

    // R5/R6 write then read every address in normal mode
    for (int a = 0; a < 256; a++) begin
      wr_reg(2'd1, 8'(a));
      wr_reg(2'd0, dpat(a));
      wr_reg(2'd2, 8'h03);
      chk(busy == 1'b1, "R2 busy after cmd", busy, 1);
      wait_idle(cyc);
      if (a == 0) norm_cyc = cyc;
    end
    for (int a = 0; a < 256; a++) begin
      read_at(a);
      chk(rd_data == dpat(a), "R5 data field", rd_data, dpat(a));
      chk(rd_code == dpat(a) % 16, "R5 code field", rd_code, dpat(a) % 16);
    end

    // R9 latency in fast init mode
    wr_reg(2'd3, 8'h02);
    wr_reg(2'd1, 8'd0);
    wr_reg(2'd0, dpat(0));
    wr_reg(2'd2, 8'h03);
    wait_idle(init_cyc);
    chk(init_cyc <= 40, "R9 init latency", init_cyc, 40);
    chk(norm_cyc >= init_cyc + 12, "R9 normal slower", norm_cyc, init_cyc + 12);

    // R5 field selects at address 5
    wr_reg(2'd1, 8'd5); wr_reg(2'd0, 8'hC3); run_cmd(8'h01, cyc);
    read_at(5);
    chk(rd_data == 8'hC3, "R5 data only: data", rd_data, 8'hC3);
    chk(rd_code == dpat(5) % 16, "R5 data only: code kept", rd_code, dpat(5) % 16);
    wr_reg(2'd0, 8'h7E); run_cmd(8'h02, cyc);
    read_at(5);
    chk(rd_code == 4'hE, "R5 code only: code", rd_code, 4'hE);
    chk(rd_data == 8'hC3, "R5 code only: data kept", rd_data, 8'hC3);
    wr_reg(2'd0, 8'h11); run_cmd(8'h00, cyc);
    read_at(5);
    chk(rd_code == 4'hE && rd_data == 8'hC3, "R5 no field", {rd_code, rd_data}, 12'hEC3);

    // R6 readback holds across a later write command
    wr_reg(2'd1, 8'd6); wr_reg(2'd0, 8'h22); run_cmd(8'h03, cyc);
    chk(rd_code == 4'hE && rd_data == 8'hC3, "R6 readback kept after write", {rd_code, rd_data}, 12'hEC3);

    // R3 lockout while busy
    wr_reg(2'd1, 8'd20); wr_reg(2'd0, 8'h44);
    wr_reg(2'd2, 8'h03);
    wr_reg(2'd0, 8'h99);
    wr_reg(2'd1, 8'd21);
    wr_reg(2'd2, 8'h03);
    chk(busy == 1'b1, "R3 still busy", busy, 1);
    wait_idle(cyc);
    repeat (60) @(negedge clk);
    chk(busy == 1'b0, "R3 no second op", busy, 0);
    read_at(20);
    chk(rd_data == 8'h44, "R3 addr20 data", rd_data, 8'h44);
    read_at(21);
    chk(rd_data == dpat(21), "R3 addr21 untouched", rd_data, dpat(21));
    wr_reg(2'd1, 8'd30); run_cmd(8'h01, cyc);
    read_at(30);
    chk(rd_data == 8'h44, "R3 data reg kept", rd_data, 8'h44);

    // R7/R8 bulk fill
    wr_reg(2'd3, 8'h00);
    wr_reg(2'd0, 8'h5A);
    run_cmd(8'h40, fill_cyc);
    chk(fill_cyc >= 256 * 3, "R8 fill min", fill_cyc, 768);
    chk(fill_cyc <= (256 + 20) * 3, "R8 fill max", fill_cyc, 828);
    wr_reg(2'd3, 8'h02);
    e1 = 0;
    for (int a = 0; a < 256; a++) begin
      read_at(a);
      if (rd_code != 0 || rd_data != 8'h5A) begin
        e1++;
        chk(1'b0, "R7 fill word", {rd_code, rd_data}, 12'h05A);
      end
    end
    chk(e1 == 0, "R7 fill all words", e1, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule